// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of a parameterised width N and returns the full 2N-bit signed product. It is purely combinational: the product follows the operands with no clock, no latency and no handshake. It is meant to sit inside a larger datapath, such as an arithmetic unit or a multiply-accumulate stage, where a registered boundary is supplied by the surrounding logic.

The multiplier operand is recoded into base-4 signed digits. Each digit looks at an overlapping window of three multiplier bits and picks one of five partial products: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. Doubling is a one-bit left shift. Negation is a bitwise inversion followed by an increment. Each partial product is sign-extended to 2N bits and shifted left by two bits per digit position. A straight ripple chain of adders then sums the partial products. An odd N is handled by widening both operands by one sign bit before recoding, so the digit count is always ceil(N/2)+1.

Top module: `booth_r4_mult`

## Requirements
- R1: For N=8, `prod_o` equals the exact signed product of `mcand_i` and `mplier_i` for every one of the 65536 operand pairs.
- R2: Digit k is taken from multiplier bits (k2+1, k2, k2-1), where bit -1 is 0. The digit values are: 000 and 111 give 0; 001 and 010 give +M; 011 gives +2M; 100 gives -2M; 101 and 110 give -M. For example, a multiplier of 2 gives digits -2 and +1, and a multiplier of 3 gives digits -1 and +1.
- R3: A doubled partial product is the multiplicand shifted left by one bit, so its least significant bit is 0. This holds even when the multiplicand is the most negative value.
- R4: A zero operand on either side gives a product of 0.
- R5: The most negative operand values are exact. At N=8, -128 times -128 gives 16384, and -128 times 127 gives -16256.
- R6: An odd N is supported. At N=7, the product is exact for all 16384 operand pairs.
- R7: Each partial product is sign-extended to 2N bits and weighted by 4 to the power k. At N=16, random operand pairs give the exact signed product.
- R8: The recoder builds ceil(N/2)+1 digits from the sign-extended multiplier. The top digit therefore covers the multiplier's sign bit, and a multiplier of -1 or of the most negative value gives the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier, recoded into base-4 digits |
| prod_o | output | 2N | Signed product |

## Verification
A wrong digit decode or a wrong partial-product sign changes `prod_o` at once, in the same evaluation as the operand change. It shows only for operand pairs whose multiplier holds the broken bit pattern at the broken digit position. Exhaustive sweeps at N=8 and N=7 therefore reach every window pattern at every position. A missing sign extension or a wrong shift weight shows mainly for negative operands and in the upper product bits, which is why the random pairs at N=16 cover the full signed range.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;

   // Recoded digit: a magnitude select (one or two) and a sign.
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_digit_t;

   // Operand width after rounding up to an even bit count.
   function automatic int unsigned even_width(input int unsigned n);
      return n + (n % 2);
   endfunction

   // Number of base-4 digits: half the even width plus one top digit.
   function automatic int unsigned digit_count(input int unsigned n);
      return even_width(n) / 2 + 1;
   endfunction

endpackage

// File: rtl/booth_r4_digit_enc.sv
module booth_r4_digit_enc
   import booth_r4_pkg::*;
(
   input  logic [2:0]   win_i,
   output booth_digit_t dig_o
);

   always_comb begin
      dig_o = '0;
      unique case (win_i)
         3'b001, 3'b010: dig_o.one = 1'b1;
         3'b011:         dig_o.two = 1'b1;
         3'b100:         begin dig_o.two = 1'b1; dig_o.neg = 1'b1; end
         3'b101, 3'b110: begin dig_o.one = 1'b1; dig_o.neg = 1'b1; end
         default:        dig_o = '0;
      endcase
      if (!$isunknown(win_i)) begin
         AST_DIGIT_EXCL: assert (!(dig_o.one && dig_o.two)) else $error("digit selects both magnitudes"); // R2
         AST_NEG_NEEDS_TOP: assert (!dig_o.neg || win_i[2]) else $error("negative digit without top window bit"); // R2
      end
   end

endmodule

// File: rtl/booth_r4_pp_gen.sv
module booth_r4_pp_gen
   import booth_r4_pkg::*;
#(
   parameter int unsigned OPW = 8,
   parameter int unsigned PPW = 16
) (
   input  logic [OPW-1:0] mcand_i,
   input  booth_digit_t   dig_i,
   output logic [PPW-1:0] pp_o
);

   localparam int unsigned EXTW = PPW - OPW;

   if (PPW <= OPW + 1) begin : g_bad_width
      $error("partial product width must exceed operand width by two or more");
   end

   logic [PPW-1:0] ext;
   logic [PPW-1:0] mag;

   always_comb begin
      ext  = {{EXTW{mcand_i[OPW-1]}}, mcand_i};
      mag  = dig_i.two ? (ext << 1) : (dig_i.one ? ext : '0);
      pp_o = dig_i.neg ? (~mag + {{(PPW-1){1'b0}}, 1'b1}) : mag;
      if (!$isunknown({mcand_i, dig_i})) begin
         AST_DOUBLE_LSB: assert (!dig_i.two || !pp_o[0]) else $error("doubled partial product has odd value"); // R3
         AST_ZERO_DIGIT: assert (dig_i.one || dig_i.two || pp_o == '0) else $error("zero digit gives nonzero term"); // R4
         AST_SIGN_EXT: assert (pp_o[PPW-1:OPW+1] == {(PPW-OPW-1){pp_o[PPW-1]}}) else $error("partial product not sign-extended"); // R7
      end
   end

endmodule

// File: rtl/booth_r4_pp_sum.sv
module booth_r4_pp_sum #(
   parameter int unsigned PPW = 16,
   parameter int unsigned NDIG = 5
) (
   input  logic [NDIG*PPW-1:0] pp_flat_i,
   output logic [PPW-1:0]      sum_o
);

   if (2 * (NDIG - 1) >= PPW) begin : g_bad_shift
      $error("digit weighting exceeds product width");
   end

   logic [PPW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int unsigned k = 0; k < NDIG; k++) begin
         acc = acc + (pp_flat_i[k*PPW +: PPW] << (2 * k));
      end
      sum_o = acc;
      if (!$isunknown(pp_flat_i)) begin
         AST_LOW_PAIR: assert (sum_o[1:0] == pp_flat_i[1:0]) else $error("low product bits not from digit zero"); // R1
      end
   end

endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
   import booth_r4_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input  logic signed [N-1:0]   mcand_i,
   input  logic signed [N-1:0]   mplier_i,
   output logic signed [2*N-1:0] prod_o
);

   localparam int unsigned NE   = even_width(N);
   localparam int unsigned NDIG = digit_count(N);
   localparam int unsigned PPW  = 2 * N;
   localparam int unsigned QW   = 2 * NDIG + 1;

   if (N < 2) begin : g_bad_n
      $error("operand width must be at least two");
   end

   logic [NE-1:0]       mcand_x;
   logic [QW-1:0]       q_win;
   logic [NDIG*PPW-1:0] pp_flat;
   logic [PPW-1:0]      sum;

   // Widen both operands by sign; bit 0 of q_win stands for multiplier bit -1.
   assign mcand_x = NE'(mcand_i);
   assign q_win   = {(QW-1)'(mplier_i), 1'b0};

   for (genvar k = 0; k < NDIG; k++) begin : g_digit
      booth_digit_t dig;

      booth_r4_digit_enc u_enc (
         .win_i (q_win[2*k+2 : 2*k]),
         .dig_o (dig)
      );

      booth_r4_pp_gen #(
         .OPW (NE),
         .PPW (PPW)
      ) u_pp (
         .mcand_i (mcand_x),
         .dig_i   (dig),
         .pp_o    (pp_flat[k*PPW +: PPW])
      );
   end

   booth_r4_pp_sum #(
      .PPW  (PPW),
      .NDIG (NDIG)
   ) u_sum (
      .pp_flat_i (pp_flat),
      .sum_o     (sum)
   );

   assign prod_o = signed'(sum);

endmodule

// File: tb/booth_r4_mult_tb.sv
module booth_r4_mult_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   bit   done = 1'b0;
   int   checks = 0;
   int   errors = 0;

   always #5ns clk = ~clk;

   logic signed [7:0]  a8 = '0, b8 = '0;
   logic signed [15:0] p8;
   logic signed [6:0]  a7 = '0, b7 = '0;
   logic signed [13:0] p7;
   logic signed [15:0] a16 = '0, b16 = '0;
   logic signed [31:0] p16;

   booth_r4_mult #(.N(8))  dut_i      (.mcand_i(a8),  .mplier_i(b8),  .prod_o(p8));
   booth_r4_mult #(.N(7))  dut_odd_i  (.mcand_i(a7),  .mplier_i(b7),  .prod_o(p7));
   booth_r4_mult #(.N(16)) dut_wide_i (.mcand_i(a16), .mplier_i(b16), .prod_o(p16));

   function automatic longint ref_mul(input longint x, input longint y);
      return x * y;
   endfunction

   task automatic check(input string req, input longint x, input longint y,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %0d * %0d gave %0d, expected %0d", req, x, y, act, exp);
      end
   endtask

   task automatic run8(input string req, input int x, input int y);
      @(posedge clk);
      a8 = 8'(x);
      b8 = 8'(y);
      @(negedge clk);
      check(req, x, y, longint'(p8), ref_mul(x, y));
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      void'($urandom(32'd20260507));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4: reset state with zero operands
      check("R4", 0, 0, longint'(p8), 0);
      rst = 1'b0;

      // R2: digit patterns, b=2 -> (-2,+1), b=3 -> (-1,+1), b=1 -> +1, b=6 -> (-2,+2)
      run8("R2", 7, 2);
      run8("R2", 7, 3);
      run8("R2", -7, 1);
      run8("R2", 5, 6);
      run8("R2", 7, -3);
      run8("R2", -9, 85);
      // R3: doubling of the most negative multiplicand
      run8("R3", -128, 2);
      run8("R3", -128, -2);
      // R4: zero on either side
      run8("R4", 0, -128);
      run8("R4", 127, 0);
      // R5: extremes
      run8("R5", -128, -128);
      run8("R5", -128, 127);
      run8("R5", 127, 127);
      // R8: top digit covers the sign
      run8("R8", 93, -1);
      run8("R8", -45, -128);

      // R1: exhaustive sweep at N=8
      for (int i = -128; i < 128; i++) begin
         for (int j = -128; j < 128; j++) begin
            run8("R1", i, j);
         end
      end

      // R6: exhaustive sweep at odd N=7
      for (int i = -64; i < 64; i++) begin
         for (int j = -64; j < 64; j++) begin
            @(posedge clk);
            a7 = 7'(i);
            b7 = 7'(j);
            @(negedge clk);
            check("R6", i, j, longint'(p7), ref_mul(i, j));
         end
      end

      // R7: random plus corners at N=16
      for (int n = 0; n < 3000; n++) begin
         int x;
         int y;
         if (n == 0) begin x = -32768; y = -32768; end
         else if (n == 1) begin x = -32768; y = 32767; end
         else if (n == 2) begin x = 32767; y = -1; end
         else begin
            x = int'($signed(16'($urandom())));
            y = int'($signed(16'($urandom())));
         end
         @(posedge clk);
         a16 = 16'(x);
         b16 = 16'(y);
         @(negedge clk);
         check("R7", x, y, longint'(p16), ref_mul(x, y));
      end

      done = 1'b1;
      summary();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, got 0, expected 1");
         summary();
      end
   end

endmodule